// File: doc/BRIEF.md
# Slot Hot-Plug Command Engine

This block executes the commands that software writes to a hot-plug controller. It serves a bridge with a configurable number of slots. Each command is a 16-bit word. The low byte is an operation code and the high byte names a target slot, counted from 1. A command can do one of three things:

- change the power/enable state of one slot, together with that slot's power and attention indicator states;
- move every slot to powered-only or enabled in one step;
- select the speed/mode of the secondary bus segment.

While a command runs, the block holds a busy flag. Power sequencing is not modelled in real time. A programmable number of busy cycles stands in for it. When busy drops, the block applies the command's effect, publishes an error code and sends a one-cycle completion pulse to the event logic. Software polls the busy bit, or waits for that completion event, and then reads the error bits.

The slot state and the two indicator fields are visible for every slot in a packed slot-register bus. The current bus speed/mode value is also an output. A parameter selects the interface level. Level 2 holds a 4-bit speed/mode value. Level 1 holds 3 bits and rejects any value above 4.

Top module: `hp_cmd_engine`

## Requirements
- R1: A command is accepted when `cmd_wr` is high and busy (status bit 0) is low. The code is taken from `cmd_word[7:0]` and the target slot from `cmd_word[15:8]`, with slot 1 as the first slot. Busy reads high in the cycle after the accepting edge.
- R2: After acceptance, busy stays high for exactly `busy_cycles` clock cycles, counting a value of 0 as 1. The value is sampled at acceptance, so later changes to the input have no effect on a running command.
- R3: On the clock edge that clears busy, three things happen together: the command's effect is applied, the error bits are updated and `cmd_done` pulses high for one cycle. Slot registers, bus mode and error bits change at no other time.
- R4: A write made while busy is high is ignored. This holds for every busy cycle, including the last one. Busy does not restart, and no state changes because of that write.
- R5: Codes 00h to 3Fh act on the target slot only, using three 2-bit fields:
  - Bits 1:0 set the slot state: 1 powered-only, 2 enabled, 3 disabled.
  - Bits 3:2 set the power indicator: 1 on, 2 blink, 3 off.
  - Bits 5:4 set the attention indicator, with the same encoding as the power indicator.
  - A field value of 0 leaves that item as it was.
- R6: Slot i (from 0) occupies `slot_regs[6i+5:6i]`: state in bits 1:0, power indicator in bits 3:2, attention indicator in bits 5:4, with the R5 encodings. Reset leaves every field at 3 (disabled, off, off).
- R7: A slot operation is refused if its state field is 1 or 2 and `latch_open` for the target slot is high at completion. The refused command changes nothing and sets status bit 1. A slot operation whose state field is 0 or 3 is executed even if the latch is open.
- R8: Status bit 2 (invalid command) is set, with no state change, in these cases:
  - a slot operation that targets slot 0;
  - a slot operation that targets a slot above `NUM_SLOTS`;
  - codes 4Ah to 4Fh;
  - codes 60h to FFh.
- R9: Code 48h puts every slot into state 1, and code 49h puts every slot into state 2. Both ignore the target byte and leave the indicators unchanged. If any `latch_open` bit is high, neither code changes anything, and status bit 1 is set.
- R10: The speed/mode codes map as follows:
  - Codes 40h to 44h set bus mode to 0 to 4.
  - Codes 50h to 5Dh set bus mode to the code minus 50h.
  - Codes 45h to 47h, 5Eh and 5Fh leave the mode unchanged and set status bit 3 (invalid speed/mode).
  - Reset sets bus mode to 0.
- R11: With `IF_LEVEL` = 1, any speed/mode value above 4 is treated as invalid and sets status bit 3. `bus_mode[3]` then stays 0.
- R12: Status bit 0 is busy. Bits 3:1 describe only the most recently completed command: all zero on success, at most one bit set otherwise. Reset clears all four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Target slot in bits 15:8, code in bits 7:0 |
| busy_cycles | input | DELAY_W | Busy duration for the next accepted command |
| latch_open | input | NUM_SLOTS | Per-slot retention latch open indication |
| status | output | 4 | {invalid speed/mode, invalid command, latch open, busy} |
| slot_regs | output | 6*NUM_SLOTS | Packed per-slot state and indicator fields |
| bus_mode | output | 4 | Current bus segment speed/mode value |
| cmd_done | output | 1 | One-cycle command completion pulse |

## Verification
The overlap that matters is a new write arriving in the same cycle that a running command completes. The last busy cycle is the sharpest case, because the write and the busy-clear edge coincide. The bench provokes this by injecting a second, different command at a random busy cycle, sometimes on purpose in the final one. It also changes `busy_cycles` during the injection. The write is judged ignored when three things hold: busy falls after exactly the original count, the results match the first command alone, and one cycle later busy is still low with no slot or mode field having moved.

// File: rtl/hp_cmd_pkg.sv
// Package: shared types and code constants for the hot-plug command engine.
// Assumes an 8-bit code byte and 2-bit slot/indicator fields.
package hp_cmd_pkg;

    // Operation class of a code byte
    typedef enum logic [2:0] {
        OP_SLOT,
        OP_SPEED,
        OP_ALL_PWR,
        OP_ALL_EN,
        OP_BAD
    } op_e;

    // Per-slot visible fields, bit order matches the slot register layout
    typedef struct packed {
        logic [1:0] attn;
        logic [1:0] pwr;
        logic [1:0] state;
    } slot_fields_t;

    // Error bits in the order they appear in status[3:1]
    typedef struct packed {
        logic bad_speed;
        logic bad_cmd;
        logic lat_err;
    } cmd_err_t;

    localparam int FIELD_W = $bits(slot_fields_t);

    localparam logic [1:0] FLD_KEEP    = 2'd0;
    localparam logic [1:0] ST_PWRONLY  = 2'd1;
    localparam logic [1:0] ST_ENABLE   = 2'd2;
    localparam logic [1:0] ST_DISABLE  = 2'd3;
    localparam logic [1:0] IND_OFF     = 2'd3;

    localparam slot_fields_t SLOT_RESET = '{attn: IND_OFF, pwr: IND_OFF, state: ST_DISABLE};

    localparam logic [7:0] CODE_PWR_ALL = 8'h48;
    localparam logic [7:0] CODE_EN_ALL  = 8'h49;
    localparam logic [3:0] SPEED_MAX_A  = 4'd4;
    localparam logic [3:0] SPEED_MAX_L1 = 4'd4;
    localparam logic [3:0] SPEED_MAX_L2 = 4'd13;

endpackage

// File: rtl/hp_busy_timer.sv
// Module: busy timer. Loads the programmed duration on start (0 counts as 1),
// holds busy for that many cycles and flags the final busy cycle.
// Assumes start is only raised while busy is low.
module hp_busy_timer #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DELAY_W-1:0] delay,
    output logic               busy,
    output logic               finish
);

    localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

    logic [DELAY_W-1:0] cnt_q;

    // Count down the remaining busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            cnt_q <= (delay == '0) ? ONE : delay;
            busy  <= 1'b1;
        end else if (busy) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) begin
                busy <= 1'b0;
            end
        end
    end

    // Last busy cycle: the command executes at the coming edge
    always_comb begin
        finish = busy && (cnt_q == ONE);
    end

endmodule

// File: rtl/hp_cmd_decode.sv
// Module: command decoder. Classifies the code byte, checks the target slot,
// latch conditions and speed/mode limits, and yields the action to apply
// plus the error code. Purely combinational; the caller gates by completion.
module hp_cmd_decode
    import hp_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int IF_LEVEL  = 2
) (
    input  logic [7:0]           code,
    input  logic [7:0]           target,
    input  logic [NUM_SLOTS-1:0] latch_open,
    output cmd_err_t             err,
    output logic [NUM_SLOTS-1:0] slot_hit,
    output slot_fields_t         fields,
    output logic                 group_en,
    output logic [1:0]           group_state,
    output logic                 speed_en,
    output logic [3:0]           speed_val
);

    localparam logic [3:0] SPEED_LIMIT = (IF_LEVEL == 1) ? SPEED_MAX_L1 : SPEED_MAX_L2;

    op_e                  op;
    logic                 form_b;
    logic                 speed_ok;
    logic [NUM_SLOTS-1:0] hit_raw;
    logic                 target_ok;
    logic                 wants_power;
    logic                 latch_blk;

    // Classify the code byte and extract the raw speed/mode value
    always_comb begin
        op        = OP_BAD;
        form_b    = 1'b0;
        speed_val = '0;
        if (code[7:6] == 2'b00) begin
            op = OP_SLOT;
        end else if (code[7:3] == 5'b01000) begin
            op        = OP_SPEED;
            speed_val = {1'b0, code[2:0]};
        end else if (code == CODE_PWR_ALL) begin
            op = OP_ALL_PWR;
        end else if (code == CODE_EN_ALL) begin
            op = OP_ALL_EN;
        end else if (code[7:4] == 4'h5) begin
            op        = OP_SPEED;
            form_b    = 1'b1;
            speed_val = code[3:0];
        end
    end

    // Per-slot target match, numbering from 1
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
        assign hit_raw[i] = (target == 8'(i + 1));
    end

    // Derived qualifiers for error selection
    always_comb begin
        fields      = slot_fields_t'(code[5:0]);
        target_ok   = |hit_raw;
        wants_power = (fields.state == ST_PWRONLY) || (fields.state == ST_ENABLE);
        latch_blk   = |(hit_raw & latch_open);
        speed_ok    = form_b ? (speed_val <= SPEED_LIMIT) : (speed_val <= SPEED_MAX_A);
    end

    // Choose the action or the error for the command
    always_comb begin
        err         = '0;
        slot_hit    = '0;
        group_en    = 1'b0;
        group_state = ST_PWRONLY;
        speed_en    = 1'b0;
        case (op)
            OP_SLOT: begin
                if (!target_ok) begin
                    err.bad_cmd = 1'b1;
                end else if (wants_power && latch_blk) begin
                    err.lat_err = 1'b1;
                end else begin
                    slot_hit = hit_raw;
                end
            end
            OP_SPEED: begin
                if (speed_ok) begin
                    speed_en = 1'b1;
                end else begin
                    err.bad_speed = 1'b1;
                end
            end
            OP_ALL_PWR, OP_ALL_EN: begin
                if (|latch_open) begin
                    err.lat_err = 1'b1;
                end else begin
                    group_en    = 1'b1;
                    group_state = (op == OP_ALL_EN) ? ST_ENABLE : ST_PWRONLY;
                end
            end
            default: begin
                err.bad_cmd = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hp_slot_bank.sv
// Module: per-slot state and indicator registers. On exec, a group action
// rewrites every slot state; otherwise the addressed slot takes each
// non-zero field. Assumes group_en and slot_hit are never both active.
module hp_slot_bank
    import hp_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         exec,
    input  logic [NUM_SLOTS-1:0]         slot_hit,
    input  slot_fields_t                 fields,
    input  logic                         group_en,
    input  logic [1:0]                   group_state,
    output logic [NUM_SLOTS*FIELD_W-1:0] slot_regs
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        slot_fields_t reg_q;

        // Hold one slot's state and indicator fields
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q <= SLOT_RESET;
            end else if (exec) begin
                if (group_en) begin
                    reg_q.state <= group_state;
                end else if (slot_hit[i]) begin
                    if (fields.state != FLD_KEEP) reg_q.state <= fields.state;
                    if (fields.pwr   != FLD_KEEP) reg_q.pwr   <= fields.pwr;
                    if (fields.attn  != FLD_KEEP) reg_q.attn  <= fields.attn;
                end
            end
        end

        assign slot_regs[i*FIELD_W +: FIELD_W] = reg_q;
    end

endmodule

// File: rtl/hp_cmd_engine.sv
// Module: top of the hot-plug command engine. Captures an accepted command,
// runs the busy timer, and on the final busy cycle applies the decoded
// action, records the error code and raises the completion pulse.
// Assumes latch_open is stable while a command is busy.
module hp_cmd_engine
    import hp_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int DELAY_W   = 8,
    parameter int IF_LEVEL  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_wr,
    input  logic [15:0]                  cmd_word,
    input  logic [DELAY_W-1:0]           busy_cycles,
    input  logic [NUM_SLOTS-1:0]         latch_open,
    output logic [3:0]                   status,
    output logic [NUM_SLOTS*6-1:0]       slot_regs,
    output logic [3:0]                   bus_mode,
    output logic                         cmd_done
);

    localparam int MODE_W = (IF_LEVEL == 1) ? 3 : 4;

    logic                 busy;
    logic                 finish;
    logic                 accept;
    logic [15:0]          cmd_q;
    cmd_err_t             dec_err;
    cmd_err_t             err_q;
    logic [NUM_SLOTS-1:0] dec_hit;
    slot_fields_t         dec_fields;
    logic                 dec_group_en;
    logic [1:0]           dec_group_state;
    logic                 dec_speed_en;
    logic [3:0]           dec_speed_val;
    logic [MODE_W-1:0]    mode_q;
    logic                 done_q;

    // New commands are taken only while idle
    always_comb begin
        accept = cmd_wr && !busy;
    end

    // Hold the accepted command word until it executes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_word;
        end
    end

    hp_busy_timer #(
        .DELAY_W (DELAY_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .delay  (busy_cycles),
        .busy   (busy),
        .finish (finish)
    );

    hp_cmd_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .IF_LEVEL  (IF_LEVEL)
    ) u_decode (
        .code        (cmd_q[7:0]),
        .target      (cmd_q[15:8]),
        .latch_open  (latch_open),
        .err         (dec_err),
        .slot_hit    (dec_hit),
        .fields      (dec_fields),
        .group_en    (dec_group_en),
        .group_state (dec_group_state),
        .speed_en    (dec_speed_en),
        .speed_val   (dec_speed_val)
    );

    hp_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec        (finish),
        .slot_hit    (dec_hit),
        .fields      (dec_fields),
        .group_en    (dec_group_en),
        .group_state (dec_group_state),
        .slot_regs   (slot_regs)
    );

    // Record the outcome, the bus mode and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            mode_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                err_q <= dec_err;
                if (dec_speed_en) begin
                    mode_q <= dec_speed_val[MODE_W-1:0];
                end
            end
        end
    end

    if (MODE_W < 4) begin : g_mode_narrow
        assign bus_mode = {{(4 - MODE_W){1'b0}}, mode_q};
    end else begin : g_mode_full
        assign bus_mode = mode_q;
    end

    assign status   = {err_q, busy};
    assign cmd_done = done_q;

endmodule

// File: rtl/hp_cmd_checker.sv
// Module: assertion checker for hp_cmd_engine, attached by bind.
// Watches ports only and keeps its own busy-length model.
module hp_cmd_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int DELAY_W   = 8,
    parameter int IF_LEVEL  = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_wr,
    input logic [DELAY_W-1:0]     busy_cycles,
    input logic [3:0]             status,
    input logic [NUM_SLOTS*6-1:0] slot_regs,
    input logic [3:0]             bus_mode,
    input logic                   cmd_done
);

    logic [DELAY_W:0] len_q;
    logic [DELAY_W:0] exp_q;

    // Independent busy-length count for the duration rule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            exp_q <= '0;
        end else if (cmd_wr && !status[0]) begin
            len_q <= '0;
            exp_q <= (busy_cycles == '0) ? (DELAY_W+1)'(1) : {1'b0, busy_cycles};
        end else if (status[0]) begin
            len_q <= len_q + 1'b1;
        end
    end

    a_r1_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !status[0]) |=> status[0]);

    a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> (len_q == exp_q));

    a_r3_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> cmd_done);

    a_r3_done_only_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $fell(status[0]));

    a_r3_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |-> ($stable(slot_regs) && $stable(bus_mode) && $stable(status[3:1])));

    a_r12_one_error: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[3:1]));

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_fld
        a_r6_fields_defined: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_regs[i*6 +: 2] != 2'd0) && (slot_regs[i*6+2 +: 2] != 2'd0)
            && (slot_regs[i*6+4 +: 2] != 2'd0));
    end

    if (IF_LEVEL == 1) begin : g_l1
        a_r11_mode_limit: assert property (@(posedge clk) disable iff (!rst_n)
            bus_mode <= 4'd4);
    end

endmodule

bind hp_cmd_engine hp_cmd_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .DELAY_W   (DELAY_W),
    .IF_LEVEL  (IF_LEVEL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .busy_cycles (busy_cycles),
    .status      (status),
    .slot_regs   (slot_regs),
    .bus_mode    (bus_mode),
    .cmd_done    (cmd_done)
);

// File: tb/sim_hp_cmd_engine.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random commands against a model of
// the requirements; a level-1 copy (u1) shares the stimulus.
module sim_hp_cmd_engine;

    localparam int NS = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr;
    logic [15:0]   cmd_word;
    logic [DW-1:0] dly;
    logic [NS-1:0] lat;

    logic [3:0]      st0, st1, bm0, bm1;
    logic [NS*6-1:0] sr0, sr1;
    logic            dn0, dn1;

    int n_chk = 0;
    int n_fail = 0;

    logic [1:0] m_st [NS];
    logic [1:0] m_pw [NS];
    logic [1:0] m_at [NS];
    logic [3:0] m_md2, m_md1;
    logic [2:0] m_er2, m_er1;

    always #4 clk = ~clk;

    hp_cmd_engine #(.NUM_SLOTS(NS), .DELAY_W(DW), .IF_LEVEL(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .busy_cycles(dly), .latch_open(lat), .status(st0), .slot_regs(sr0),
        .bus_mode(bm0), .cmd_done(dn0));

    hp_cmd_engine #(.NUM_SLOTS(NS), .DELAY_W(DW), .IF_LEVEL(1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .busy_cycles(dly), .latch_open(lat), .status(st1), .slot_regs(sr1),
        .bus_mode(bm1), .cmd_done(dn1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NS*6-1:0] exp_regs();
        logic [NS*6-1:0] r;
        for (int i = 0; i < NS; i++) r[i*6 +: 6] = {m_at[i], m_pw[i], m_st[i]};
        return r;
    endfunction

    // Expected effect of one command, per the requirements
    task automatic model_exec(input logic [15:0] w, output string tag);
        logic [7:0] c;
        int s;
        int v;
        c = w[7:0];
        s = int'(w[15:8]);
        m_er2 = 3'b000;
        m_er1 = 3'b000;
        if (c < 8'h40) begin
            if (s == 0 || s > NS) begin
                m_er2 = 3'b010; m_er1 = 3'b010; tag = "R8 bad target";
            end else if ((c[1:0] == 2'd1 || c[1:0] == 2'd2) && lat[s-1]) begin
                m_er2 = 3'b001; m_er1 = 3'b001; tag = "R7 latch open";
            end else begin
                if (c[1:0] != 0) m_st[s-1] = c[1:0];
                if (c[3:2] != 0) m_pw[s-1] = c[3:2];
                if (c[5:4] != 0) m_at[s-1] = c[5:4];
                tag = "R5 slot op";
            end
        end else if (c <= 8'h47) begin
            v = int'(c) - 'h40;
            if (v <= 4) begin
                m_md2 = 4'(v); m_md1 = 4'(v); tag = "R10 form A";
            end else begin
                m_er2 = 3'b100; m_er1 = 3'b100; tag = "R10 bad form A";
            end
        end else if (c == 8'h48 || c == 8'h49) begin
            if (|lat) begin
                m_er2 = 3'b001; m_er1 = 3'b001; tag = "R9 group latch";
            end else begin
                for (int i = 0; i < NS; i++) m_st[i] = (c == 8'h49) ? 2'd2 : 2'd1;
                tag = "R9 group";
            end
        end else if (c >= 8'h50 && c <= 8'h5F) begin
            v = int'(c) - 'h50;
            if (v <= 13) m_md2 = 4'(v); else m_er2 = 3'b100;
            if (v <= 4)  m_md1 = 4'(v); else m_er1 = 3'b100;
            tag = (v > 4) ? "R11 form B" : "R10 form B";
        end else begin
            m_er2 = 3'b010; m_er1 = 3'b010; tag = "R8 reserved";
        end
    endtask

    // Issue a command at the current negedge and check its completion
    task automatic run_cmd(input logic [15:0] w, input int d, input int inj, input logic [15:0] junk);
        int deff;
        int cyc;
        string tag;
        logic [NS*6-1:0] keep_regs;
        logic [3:0] keep_mode;
        deff = (d == 0) ? 1 : d;
        cmd_word = w;
        dly = DW'(d);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R1 busy after accept", 32'(st0[0]), 32'd1);
        cyc = 0;
        while (st0[0] && cyc < 300) begin
            cyc++;
            if (cyc == inj) begin
                cmd_wr = 1'b1; cmd_word = junk; dly = DW'(1);
            end
            @(negedge clk);
            cmd_wr = 1'b0;
        end
        model_exec(w, tag);
        chk("R2 busy length", 32'(cyc), 32'(deff));
        chk("R3 done at busy fall", 32'(dn0), 32'd1);
        chk({tag, " R12 status"}, 32'(st0), 32'({m_er2, 1'b0}));
        chk({tag, " R6 slot regs"}, 32'(sr0), 32'(exp_regs()));
        chk({tag, " R10 mode"}, 32'(bm0), 32'(m_md2));
        chk({tag, " R11 level1 status"}, 32'(st1), 32'({m_er1, 1'b0}));
        chk({tag, " R11 level1 mode"}, 32'(bm1), 32'(m_md1));
        keep_regs = sr0;
        keep_mode = bm0;
        @(negedge clk);
        chk("R3 done one cycle", 32'(dn0), 32'd0);
        if (inj != 0) begin
            chk("R4 busy not restarted", 32'(st0[0]), 32'd0);
            chk("R4 slots untouched", 32'(sr0), 32'(keep_regs));
            chk("R4 mode untouched", 32'(bm0), 32'(keep_mode));
        end
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R1 watchdog actual=hung expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] w;
        int d;
        int inj;
        void'($urandom(32'd4711));
        cmd_wr = 1'b0; cmd_word = '0; dly = '0; lat = '0;
        for (int i = 0; i < NS; i++) begin
            m_st[i] = 2'd3; m_pw[i] = 2'd3; m_at[i] = 2'd3;
        end
        m_md2 = '0; m_md1 = '0; m_er2 = '0; m_er1 = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R12 reset status", 32'(st0), 32'd0);
        chk("R6 reset slot regs", 32'(sr0), 32'hFFFFFF);
        chk("R10 reset mode", 32'(bm0), 32'd0);
        chk("R3 reset done", 32'(dn0), 32'd0);

        run_cmd({8'd1, 8'h02}, 3, 0, 16'h0);
        run_cmd({8'd2, 8'h19}, 0, 0, 16'h0);
        chk("R5 slot2 fields", 32'(sr0[11:6]), 32'h19);
        run_cmd({8'd0, 8'h02}, 2, 0, 16'h0);
        run_cmd({8'd5, 8'h02}, 2, 0, 16'h0);
        lat = 4'b0100;
        run_cmd({8'd3, 8'h02}, 2, 0, 16'h0);
        chk("R7 status bit1", 32'(st0), 32'h2);
        run_cmd({8'd3, 8'h30}, 1, 0, 16'h0);
        run_cmd({8'd3, 8'h03}, 1, 0, 16'h0);
        run_cmd({8'd0, 8'h49}, 2, 0, 16'h0);
        lat = '0;
        run_cmd({8'd0, 8'h49}, 2, 0, 16'h0);
        run_cmd({8'd7, 8'h48}, 2, 0, 16'h0);
        run_cmd({8'd0, 8'h44}, 1, 0, 16'h0);
        run_cmd({8'd0, 8'h5D}, 2, 0, 16'h0);
        chk("R10 mode D", 32'(bm0), 32'hD);
        chk("R11 level1 rejects D", 32'(st1), 32'h8);
        run_cmd({8'd0, 8'h5E}, 1, 0, 16'h0);
        run_cmd({8'd0, 8'h45}, 1, 0, 16'h0);
        run_cmd({8'd0, 8'h4A}, 1, 0, 16'h0);
        run_cmd({8'd0, 8'hC0}, 1, 0, 16'h0);
        run_cmd({8'd1, 8'h03}, 4, 4, {8'd1, 8'h01});
        run_cmd({8'd4, 8'h2A}, 1, 1, {8'd0, 8'h43});
        run_cmd({8'd2, 8'h3F}, 6, 3, {8'd2, 8'h01});

        for (int k = 0; k < 250; k++) begin
            case ($urandom % 8)
                0, 1, 2: w = {8'($urandom % (NS + 2)), 8'($urandom % 64)};
                3:       w = {8'($urandom), 8'(8'h40 + $urandom % 8)};
                4:       w = {8'($urandom), 8'(8'h50 + $urandom % 16)};
                5:       w = {8'($urandom), (($urandom % 2) != 0) ? 8'h49 : 8'h48};
                6:       w = {8'($urandom), (($urandom % 2) != 0) ? 8'(8'h4A + $urandom % 6)
                                                                : 8'(8'h60 + $urandom % 160)};
                default: w = {8'(1 + $urandom % NS), {2'b00, 4'($urandom), 2'b00}};
            endcase
            lat = (($urandom % 4) == 0) ? NS'($urandom) : '0;
            d = (($urandom % 10) == 0) ? 12 : int'($urandom % 6);
            inj = (($urandom % 3) == 0) ? 1 + int'($urandom % ((d == 0) ? 1 : d)) : 0;
            run_cmd(w, d, inj, 16'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule